// File: doc/BRIEF.md
# Audio Master Clock Divider

This block turns a fast audio source clock into the timing pulses that an audio serializer needs. Two 6-bit ratio fields set the timing. The divider field sets the master clock to the source rate divided by (divider+1). The frame field sets the frame rate to the source rate divided by 32·(frame+1). Together they give master clock = 32·(frame+1)/(divider+1) · frame rate. For example, divider 7 and frame 63 take a 98.304 MHz source to a 12.288 MHz master clock, which is 256 times a 48 kHz frame rate.

The block drives no gated clocks. Every output is a one-cycle enable pulse in the source clock domain: a master-clock enable, a bit enable and a frame enable. The bit enable places 64 bit slots (two slots of 32 bits) across each frame. A start command latches the ratio fields and the output-mode bit, and the frame then begins on a counter-zero alignment. A stop command clears the latched fields and holds every counter at zero. A status output shows whether the generator is running. The mode bit chooses between two uses: the generated master clock feeds the master-clock pin, or no master clock is made and the selected clock feeds the bit-clock pin.

Top module: `audio_mclk_gen`

## Requirements
- R1: After reset, gen_running, mck_en, bit_en, frame_en and mck_pin_sel are all 0.
- R2: When cmd_start is high, cmd_stop is low and the generator is stopped, the inputs cfg_mck_div, cfg_frame_ratio and cfg_mck_gen are latched at that edge and gen_running is 1 from the next cycle. In that first running cycle frame_en and bit_en are 1, and mck_en is 1 if cfg_mck_gen was 1.
- R3: While running with the latched mode bit at 1, mck_en pulses once every (divider+1) cycles, starting in the first running cycle.
- R4: While running, frame_en pulses once every 32·(frame+1) cycles, starting in the first running cycle.
- R5: Let c be the cycle index within a frame and N = frame+1. bit_en is 1 when c = 0, or when floor(2c/N) differs from floor((2c-2)/N). This gives 64 pulses per frame for N ≥ 2, and a pulse on every cycle for N = 1.
- R6: mck_pin_sel equals the latched mode bit while running. When the mode bit is 0, mck_en stays 0 while bit_en and frame_en keep running.
- R7: cmd_stop brings gen_running and all enables to 0 in the next cycle and clears the latched fields. It takes priority over a cmd_start in the same cycle.
- R8: A cmd_start while running is ignored: there is no realignment and no change to the latched ratios or mode.
- R9: The number of mck_en pulses per frame is 256 for divider 7 / frame 63, 64 for divider 7 / frame 15, and 1024 for divider 1 / frame 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle start command |
| cmd_stop | input | 1 | One-cycle stop command |
| cfg_mck_div | input | 6 | Master-clock divider field |
| cfg_frame_ratio | input | 6 | Frame-ratio field |
| cfg_mck_gen | input | 1 | 1: generate the master clock; 0: bit-clock pin mode |
| mck_en | output | 1 | Master-clock enable pulse |
| bit_en | output | 1 | Bit-clock enable pulse |
| frame_en | output | 1 | Frame-sync enable pulse |
| mck_pin_sel | output | 1 | Latched output-mode selection |
| gen_running | output | 1 | Generator running status |

## Verification
The bench targets these corner cases:
- A frame field of 0. Here N = 1, and a bit spacing rule that ignores saturation would skip pulses or count past the frame.
- An odd N such as 3. A design that rounds the half-cycle bit period would then drift against the frame pulse.
- Divider 0, where the master-clock enable is high on every cycle.
- A start in the same cycle as a stop, or a start while running. A design that gave start priority, or re-latched the fields, would realign or retime the frame in the middle of a stream.
- The three named ratios, whose per-frame pulse counts expose any off-by-one in either limit.

// File: rtl/amg_pkg.sv
package amg_pkg;
  localparam int DIV_W     = 6;
  localparam int FSR_W     = 6;
  localparam int SLOT_BITS = 32;
  localparam int SLOTS     = 2;
  localparam int LOG_SLOT  = $clog2(SLOT_BITS);
  localparam int FCW       = FSR_W + LOG_SLOT;
  localparam int ACW       = FSR_W + 2;

  // last index of a frame: SLOT_BITS*(fsr+1)-1 (SLOT_BITS a power of two)
  function automatic logic [FCW-1:0] frame_last(input logic [FSR_W-1:0] fsr);
    return {fsr, {LOG_SLOT{1'b1}}};
  endfunction

  // bit phase holds (SLOTS*c) mod (fsr+1)
  function automatic logic [ACW-1:0] bit_phase_next(input logic [ACW-1:0] r,
                                                    input logic [FSR_W-1:0] fsr);
    logic [ACW-1:0] n;
    logic [ACW-1:0] t;
    n = ACW'(fsr) + ACW'(1);
    t = r + ACW'(SLOTS);
    for (int i = 0; i < SLOTS; i++)
      if (t >= n) t = t - n;
    return t;
  endfunction

  function automatic logic bit_due(input logic [ACW-1:0] r);
    return r < ACW'(SLOTS);
  endfunction
endpackage

// File: rtl/amg_ctrl.sv
module amg_ctrl #(
  parameter int DIV_W = amg_pkg::DIV_W,
  parameter int FSR_W = amg_pkg::FSR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FSR_W-1:0] cfg_fsr,
  input  logic             cfg_gen,
  output logic             running,
  output logic [DIV_W-1:0] div_q,
  output logic [FSR_W-1:0] fsr_q,
  output logic             gen_q
);
  logic start_ok;
  assign start_ok = cmd_start && !cmd_stop && !running;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_stop) begin
      running <= 1'b0;
      div_q   <= '0;
      fsr_q   <= '0;
      gen_q   <= 1'b0;
    end else if (start_ok) begin
      running <= 1'b1;
      div_q   <= cfg_div;
      fsr_q   <= cfg_fsr;
      gen_q   <= cfg_gen;
    end
  end
endmodule

// File: rtl/amg_ratio_cnt.sv
module amg_ratio_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] last,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)     cnt <= '0;
    else if (cnt == last)   cnt <= '0;
    else                    cnt <= cnt + W'(1);
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/amg_bit_phase.sv
module amg_bit_phase #(
  parameter int FSR_W = amg_pkg::FSR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [FSR_W-1:0] fsr,
  output logic             due
);
  import amg_pkg::*;
  logic [ACW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) phase <= '0;
    else                phase <= bit_phase_next(phase, fsr);
  end

  assign due = run && bit_due(phase);
endmodule

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen
  import amg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [DIV_W-1:0] cfg_mck_div,
  input  logic [FSR_W-1:0] cfg_frame_ratio,
  input  logic             cfg_mck_gen,
  output logic             mck_en,
  output logic             bit_en,
  output logic             frame_en,
  output logic             mck_pin_sel,
  output logic             gen_running
);
  logic [DIV_W-1:0] cur_div;
  logic [FSR_W-1:0] cur_fsr;
  logic             cur_mode;
  logic             mck_tick;
  logic             frame_tick;
  logic             bit_tick;

  amg_ctrl #(.DIV_W(DIV_W), .FSR_W(FSR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cfg_div(cfg_mck_div), .cfg_fsr(cfg_frame_ratio), .cfg_gen(cfg_mck_gen),
    .running(gen_running), .div_q(cur_div), .fsr_q(cur_fsr), .gen_q(cur_mode)
  );

  amg_ratio_cnt #(.W(DIV_W)) u_mck_cnt (
    .clk(clk), .rst_n(rst_n), .run(gen_running), .last(cur_div), .tick(mck_tick)
  );

  amg_ratio_cnt #(.W(FCW)) u_frame_cnt (
    .clk(clk), .rst_n(rst_n), .run(gen_running), .last(frame_last(cur_fsr)),
    .tick(frame_tick)
  );

  amg_bit_phase #(.FSR_W(FSR_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .run(gen_running), .fsr(cur_fsr), .due(bit_tick)
  );

  assign mck_en      = mck_tick && cur_mode;
  assign bit_en      = bit_tick;
  assign frame_en    = frame_tick;
  assign mck_pin_sel = cur_mode;
endmodule

// File: rtl/amg_checker.sv
module amg_checker #(
  parameter int DIV_W = amg_pkg::DIV_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             gen_running,
  input logic             mck_en,
  input logic             bit_en,
  input logic             frame_en,
  input logic [DIV_W-1:0] cur_div,
  input logic             cur_mode
);
  a_r2_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_running) |-> (frame_en && bit_en));

  a_r3_mck_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mck_en && cur_div != '0) |=> !mck_en);

  a_r5_frame_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |-> bit_en);

  a_r6_no_mck_pin_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_running && !cur_mode) |-> !mck_en);

  a_r7_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !gen_running);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_running |-> !(mck_en || bit_en || frame_en));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_running && cmd_start && !cmd_stop) |=> (gen_running && $stable(cur_div)));
endmodule

bind audio_mclk_gen amg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .gen_running(gen_running), .mck_en(mck_en), .bit_en(bit_en),
  .frame_en(frame_en), .cur_div(cur_div), .cur_mode(cur_mode)
);

// File: tb/sim_audio_mclk_gen.sv
module sim_audio_mclk_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, cfg_mck_gen = 1'b0;
  logic [5:0] cfg_mck_div = '0, cfg_frame_ratio = '0;
  logic mck_en, bit_en, frame_en, mck_pin_sel, gen_running;

  int tests = 0, fails = 0, cyc = 0;
  // reference model state
  int m_run = 0, m_div = 0, m_n = 1, m_mode = 0, m_c = 0;
  // per-frame ratio monitor
  int exp_ratio = 0, ratio_cnt = 0, seen_frame = 0;

  always #2 clk = ~clk;

  audio_mclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cfg_mck_div(cfg_mck_div), .cfg_frame_ratio(cfg_frame_ratio),
    .cfg_mck_gen(cfg_mck_gen), .mck_en(mck_en), .bit_en(bit_en),
    .frame_en(frame_en), .mck_pin_sel(mck_pin_sel), .gen_running(gen_running)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_bit(int c, int n);
    int p;
    p = c % (32 * n);
    return (p == 0 || (2 * p) / n != (2 * p - 2) / n) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_div = 0; m_n = 1; m_mode = 0; m_c = 0;
    end else if (cmd_stop) begin
      m_run = 0; m_div = 0; m_n = 1; m_mode = 0; m_c = 0;
    end else if (cmd_start && m_run == 0) begin
      m_run = 1; m_div = cfg_mck_div; m_n = cfg_frame_ratio + 1;
      m_mode = cfg_mck_gen; m_c = 0;
    end else if (m_run != 0) begin
      m_c++;
    end
  end

  always @(negedge clk) begin
    int e_m, e_f, e_b;
    cyc++;
    if (rst_n) begin
      e_m = (m_run != 0 && m_mode != 0 && (m_c % (m_div + 1)) == 0) ? 1 : 0;
      e_f = (m_run != 0 && (m_c % (32 * m_n)) == 0) ? 1 : 0;
      e_b = (m_run != 0) ? exp_bit(m_c, m_n) : 0;
      check(gen_running == m_run[0], "R2/R7 gen_running", gen_running, m_run);
      check(mck_en == e_m[0], "R3 mck_en", mck_en, e_m);
      check(frame_en == e_f[0], "R4 frame_en", frame_en, e_f);
      check(bit_en == e_b[0], "R5 bit_en", bit_en, e_b);
      check(mck_pin_sel == (m_run != 0 && m_mode != 0), "R6 mck_pin_sel",
            mck_pin_sel, (m_run != 0 && m_mode != 0) ? 1 : 0);
      if (!gen_running) seen_frame = 0;
      else if (frame_en) begin
        if (seen_frame != 0 && exp_ratio > 0)
          check(ratio_cnt == exp_ratio, "R9 mck pulses per frame", ratio_cnt, exp_ratio);
        seen_frame = 1;
        ratio_cnt = mck_en ? 1 : 0;
      end else if (mck_en) ratio_cnt++;
    end
    if (cyc > 190000) begin
      check(1'b0, "watchdog", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic start(input int div, input int fsr, input int gen, input int ratio);
    @(negedge clk);
    cfg_mck_div = 6'(div); cfg_frame_ratio = 6'(fsr); cfg_mck_gen = gen[0];
    cmd_start = 1'b1; exp_ratio = ratio;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1 reset state
    check(!gen_running && !mck_en && !bit_en && !frame_en && !mck_pin_sel,
          "R1 reset outputs", {gen_running, mck_en, bit_en, frame_en, mck_pin_sel}, 0);
    rst_n = 1'b1;
    idle(2);
    // R9 256x ratio, R2 start
    start(7, 63, 1, 256);
    idle(1500);
    // R8 start while running with other settings: ignored
    @(negedge clk); cfg_mck_div = 6'd2; cfg_frame_ratio = 6'd4; cfg_mck_gen = 1'b0; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    idle(3600);
    stop();
    idle(5);
    // R9 64x ratio
    start(7, 15, 1, 64);
    idle(1200);
    // R7 stop and start together: stop wins
    @(negedge clk); cmd_stop = 1'b1; cmd_start = 1'b1;
    @(negedge clk); cmd_stop = 1'b0; cmd_start = 1'b0;
    idle(4);
    // R9 1024x ratio
    start(1, 63, 1, 1024);
    idle(4400);
    stop();
    // R5 N=1 saturation, R6 no master clock, divider 0
    start(0, 0, 0, 0);
    idle(200);
    stop();
    // R5 odd N, R3 divider 0 with generation
    start(0, 2, 1, 96);
    idle(400);
    stop();
    start(5, 2, 1, 16);
    idle(500);
    // restart directly after stop realigns to counter zero
    stop();
    start(3, 9, 1, 80);
    idle(1000);
    stop();
    idle(5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule